// File: doc/BRIEF.md
# Telephone Keypad Key Decoder

This block turns the raw row and column lines of a twelve-key telephone keypad into a four-bit key code and a flag. The flag says that exactly one key is held. The keypad has four row lines and three column lines. Every line rests high and goes low while a key on it is pressed. The code map is fixed and not sequential. The digits 0 to 9 give their own value, star gives 10 and hash gives 15. The outputs can drive five indicator LEDs directly, or they can feed a clocked consumer.

The lines come from mechanical switches, so each one first passes through a two-flop synchronizer. A counter-based filter follows, which accepts a new level only after that level has held for a set number of clock cycles. The rows and columns that the filter accepts are then decoded. The result is captured in an output register, so the code and flag are glitch-free and change only on a clock edge.

Keys are laid out by row, top to bottom, and by column, left to right:

| Row | Col 0 | Col 1 | Col 2 |
|-----|-------|-------|-------|
| 0   | 1     | 2     | 3     |
| 1   | 4     | 5     | 6     |
| 2   | 7     | 8     | 9     |
| 3   | *     | 0     | #     |

Top module: `keypad_decoder`

## Requirements
- R1: A single held key in rows 0 to 2, column c, yields code 3*row+c+1. The key at row 3, column 1 yields code 0. In every such case the valid flag is 1. Row r is input bit r of `rowN` and column c is input bit c of `colN`, both active low.
- R2: A single held key at row 3, column 0 (star) yields code 10 with valid 1.
- R3: A single held key at row 3, column 2 (hash) yields code 15 with valid 1.
- R4: When no line is low, valid is 0. Whenever valid is 0 the code output reads 0000.
- R5: If more than one row line or more than one column line is low, valid is 0 and the code is 0000. This covers two keys in one row, two keys in one column and two keys on different rows and columns.
- R6: An active-high synchronous reset treats every filtered line as idle high, so valid is 0 and the code is 0000 on the cycle after reset. A key held across reset is reported again only after the full filter delay.
- R7: A level on an input line that lasts fewer than `DEBOUNCE_CYCLES` clock cycles is ignored, and the outputs do not change.
- R8: When a line changes and then holds steady, the outputs show the new state on the rising edge `DEBOUNCE_CYCLES`+3 after the change, counting the first edge that samples the new level as edge 1. They do not show it earlier.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| rowN | input | 4 | Raw row lines, low while a key on that row is pressed |
| colN | input | 3 | Raw column lines, low while a key on that column is pressed |
| keyCode | output | 4 | Registered key code, 0000 when not valid |
| keyValid | output | 1 | Registered flag, 1 when exactly one key is held |

## Verification
Suppose a filter counter is stuck or mis-sized. The effect is a valid rise one or more cycles away from edge `DEBOUNCE_CYCLES`+3, or a short pulse that gets through the filter. Both are visible within about twenty cycles of the stimulus. A wrong entry in the code map or a wrong one-hot test shows up on the next registered output. It appears as a wrong code for a single key, or as valid 1 for a two-key pattern, and it is visible as soon as the filtered lines settle. A reset that fails to restore the idle level keeps an old code on the outputs on the cycle after reset.

// File: rtl/keypad_pkg.sv
package keypad_pkg;
  localparam int KP_ROWS   = 4;
  localparam int KP_COLS   = 3;
  localparam int KP_CODE_W = 4;
  localparam int KP_ROW_IW = $clog2(KP_ROWS);
  localparam int KP_COL_IW = $clog2(KP_COLS);

  // Strobes from control to the output datapath
  typedef struct packed {
    logic                 oneKey;   // exactly one row and one column active
    logic [KP_ROWS-1:0]   rowHit;   // active-high row hits
    logic [KP_COLS-1:0]   colHit;   // active-high column hits
  } decodeStrobe_t;

  // Fixed key map: rows 0..2 are digits, row 3 is star/0/hash
  function automatic logic [KP_CODE_W-1:0] keyMap(
      input logic [KP_ROW_IW-1:0] rowIdx,
      input logic [KP_COL_IW-1:0] colIdx);
    logic [KP_CODE_W-1:0] codeVal;
    if (rowIdx == KP_ROW_IW'(KP_ROWS - 1)) begin
      case (colIdx)
        KP_COL_IW'(0): codeVal = KP_CODE_W'(10);
        KP_COL_IW'(1): codeVal = KP_CODE_W'(0);
        default:       codeVal = KP_CODE_W'(15);
      endcase
    end else begin
      codeVal = KP_CODE_W'(rowIdx) * KP_CODE_W'(KP_COLS)
              + KP_CODE_W'(colIdx) + KP_CODE_W'(1);
    end
    return codeVal;
  endfunction
endpackage

// File: rtl/keypad_line_filter.sv
module keypad_line_filter #(
  parameter int NUM_LINES   = 7,
  parameter int SYNC_STAGES = 2,
  parameter int HOLD_CYCLES = 16
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [NUM_LINES-1:0] rawLines,
  output logic [NUM_LINES-1:0] stableLines
);
  localparam int CNT_W = (HOLD_CYCLES > 1) ? $clog2(HOLD_CYCLES) : 1;
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(HOLD_CYCLES - 1);

  for (genvar gLine = 0; gLine < NUM_LINES; gLine++) begin : gLineFilter
    logic [SYNC_STAGES-1:0] syncChain;
    logic [CNT_W-1:0]       holdCnt;
    logic                   lineState;
    logic                   syncLevel;

    assign syncLevel = syncChain[SYNC_STAGES-1];

    // Metastability chain, idles high
    always_ff @(posedge clk) begin
      if (rst) syncChain <= '1;
      else     syncChain <= {syncChain[SYNC_STAGES-2:0], rawLines[gLine]};
    end

    // Accept a new level only after it has held HOLD_CYCLES cycles
    always_ff @(posedge clk) begin
      if (rst) begin
        lineState <= 1'b1;
        holdCnt   <= '0;
      end else if (syncLevel != lineState) begin
        if (holdCnt == CNT_LAST) begin
          lineState <= syncLevel;
          holdCnt   <= '0;
        end else begin
          holdCnt <= holdCnt + CNT_W'(1);
        end
      end else begin
        holdCnt <= '0;
      end
    end

    assign stableLines[gLine] = lineState;
  end
endmodule

// File: rtl/keypad_decode_ctrl.sv
module keypad_decode_ctrl
  import keypad_pkg::*;
(
  input  logic [KP_ROWS-1:0] dbRows,
  input  logic [KP_COLS-1:0] dbCols,
  output decodeStrobe_t      strobe
);
  logic [KP_ROWS-1:0] rowHit;
  logic [KP_COLS-1:0] colHit;
  logic               rowSingle;
  logic               colSingle;

  assign rowHit = ~dbRows;
  assign colHit = ~dbCols;

  // Single-hot test: non-zero and no two bits set (x & (x-1) == 0)
  always_comb begin
    rowSingle = (rowHit != '0) && ((rowHit & (rowHit - KP_ROWS'(1))) == '0);
    colSingle = (colHit != '0) && ((colHit & (colHit - KP_COLS'(1))) == '0);
  end

  always_comb begin
    strobe.oneKey = rowSingle && colSingle;
    strobe.rowHit = rowHit;
    strobe.colHit = colHit;
  end
endmodule

// File: rtl/keypad_code_path.sv
module keypad_code_path
  import keypad_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst,
  input  decodeStrobe_t        strobe,
  output logic [KP_CODE_W-1:0] keyCode,
  output logic                 keyValid
);
  logic [KP_ROW_IW-1:0] rowIdx;
  logic [KP_COL_IW-1:0] colIdx;
  logic [KP_CODE_W-1:0] nextCode;

  // One-hot to index; only meaningful when oneKey is set
  always_comb begin
    rowIdx = '0;
    for (int r = 0; r < KP_ROWS; r++)
      if (strobe.rowHit[r]) rowIdx = KP_ROW_IW'(r);
  end

  always_comb begin
    colIdx = '0;
    for (int c = 0; c < KP_COLS; c++)
      if (strobe.colHit[c]) colIdx = KP_COL_IW'(c);
  end

  assign nextCode = strobe.oneKey ? keyMap(rowIdx, colIdx) : '0;

  always_ff @(posedge clk) begin
    if (rst) begin
      keyCode  <= '0;
      keyValid <= 1'b0;
    end else begin
      keyCode  <= nextCode;
      keyValid <= strobe.oneKey;
    end
  end
endmodule

// File: rtl/keypad_decoder.sv
module keypad_decoder
  import keypad_pkg::*;
#(
  parameter int DEBOUNCE_CYCLES = 16,
  parameter int SYNC_STAGES     = 2
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [KP_ROWS-1:0]   rowN,
  input  logic [KP_COLS-1:0]   colN,
  output logic [KP_CODE_W-1:0] keyCode,
  output logic                 keyValid
);
  localparam int LINES = KP_ROWS + KP_COLS;

  logic [LINES-1:0]   dbLines;
  logic [KP_ROWS-1:0] dbRows;
  logic [KP_COLS-1:0] dbCols;
  decodeStrobe_t      strobe;

  keypad_line_filter #(
    .NUM_LINES  (LINES),
    .SYNC_STAGES(SYNC_STAGES),
    .HOLD_CYCLES(DEBOUNCE_CYCLES)
  ) i_filter (
    .clk        (clk),
    .rst        (rst),
    .rawLines   ({colN, rowN}),
    .stableLines(dbLines)
  );

  assign dbRows = dbLines[KP_ROWS-1:0];
  assign dbCols = dbLines[LINES-1:KP_ROWS];

  keypad_decode_ctrl i_ctrl (
    .dbRows(dbRows),
    .dbCols(dbCols),
    .strobe(strobe)
  );

  keypad_code_path i_path (
    .clk     (clk),
    .rst     (rst),
    .strobe  (strobe),
    .keyCode (keyCode),
    .keyValid(keyValid)
  );
endmodule

// File: rtl/keypad_decoder_checker.sv
module keypad_decoder_checker
  import keypad_pkg::*;
(
  input logic                 clk,
  input logic                 rst,
  input logic [KP_ROWS-1:0]   dbRows,
  input logic [KP_COLS-1:0]   dbCols,
  input logic [KP_CODE_W-1:0] keyCode,
  input logic                 keyValid
);
  assert_legal_code_R1: assert property (@(posedge clk) disable iff (rst)
    keyValid |-> (keyCode <= 4'd10 || keyCode == 4'd15));

  assert_star_code_R2: assert property (@(posedge clk) disable iff (rst)
    (dbRows == 4'b0111 && dbCols == 3'b110) |=> (keyValid && keyCode == 4'd10));

  assert_hash_code_R3: assert property (@(posedge clk) disable iff (rst)
    (dbRows == 4'b0111 && dbCols == 3'b011) |=> (keyValid && keyCode == 4'd15));

  assert_invalid_zero_R4: assert property (@(posedge clk) disable iff (rst)
    !keyValid |-> (keyCode == '0));

  assert_idle_invalid_R4: assert property (@(posedge clk) disable iff (rst)
    (&dbRows && &dbCols) |=> !keyValid);

  assert_multi_invalid_R5: assert property (@(posedge clk) disable iff (rst)
    ($countones(~dbRows) > 1 || $countones(~dbCols) > 1) |=> !keyValid);

  assert_reset_idle_R6: assert property (@(posedge clk)
    rst |=> (!keyValid && keyCode == '0 && &dbRows && &dbCols));
endmodule

bind keypad_decoder keypad_decoder_checker i_checker (
  .clk     (clk),
  .rst     (rst),
  .dbRows  (dbRows),
  .dbCols  (dbCols),
  .keyCode (keyCode),
  .keyValid(keyValid)
);

// File: tb/test_keypad_decoder.sv
module test_keypad_decoder;
  localparam int N = 16;
  localparam int SETTLE = N + 8;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [3:0] rowN = 4'hF;
  logic [2:0] colN = 3'h7;
  logic [3:0] keyCode;
  logic       keyValid;

  int testsRun = 0;
  int testsFailed = 0;

  always #10 clk = ~clk;  // 50 MHz

  keypad_decoder #(.DEBOUNCE_CYCLES(N)) i_keypad_decoder (
    .clk(clk), .rst(rst), .rowN(rowN), .colN(colN),
    .keyCode(keyCode), .keyValid(keyValid)
  );

  task automatic check(input string req, input logic expValid, input logic [3:0] expCode);
    testsRun++;
    if (keyValid !== expValid || keyCode !== expCode) begin
      testsFailed++;
      $display("FAIL %s: valid=%0b code=%0d expected valid=%0b code=%0d",
               req, keyValid, keyCode, expValid, expCode);
    end
  endtask

  task automatic drive(input logic [3:0] r, input logic [2:0] c);
    @(negedge clk);
    rowN = r;
    colN = c;
  endtask

  task automatic settle();
    repeat (SETTLE) @(posedge clk);
    @(negedge clk);
  endtask

  function automatic logic [3:0] expectCode(input int r, input int c);
    if (r < 3) return 4'(3 * r + c + 1);
    if (c == 0) return 4'd10;
    if (c == 1) return 4'd0;
    return 4'd15;
  endfunction

  task automatic testReset();
    @(negedge clk);
    check("R6 reset state", 1'b0, 4'd0);
  endtask

  task automatic testAllKeys();
    for (int r = 0; r < 4; r++) begin
      for (int c = 0; c < 3; c++) begin
        drive(~(4'b1 << r), ~(3'b1 << c));
        settle();
        if (r == 3 && c == 0)      check("R2 star", 1'b1, 4'd10);
        else if (r == 3 && c == 2) check("R3 hash", 1'b1, 4'd15);
        else                       check("R1 single key", 1'b1, expectCode(r, c));
        drive(4'hF, 3'h7);
        settle();
        check("R4 released", 1'b0, 4'd0);
      end
    end
  endtask

  task automatic testMulti();
    drive(4'b1110, 3'b100);   // two keys, same row
    settle();
    check("R5 same row", 1'b0, 4'd0);
    drive(4'b1010, 3'b110);   // two keys, same column
    settle();
    check("R5 same column", 1'b0, 4'd0);
    drive(4'b0110, 3'b010);   // diagonal pair
    settle();
    check("R5 diagonal", 1'b0, 4'd0);
    drive(4'b1111, 3'b110);   // column only, no row
    settle();
    check("R4 column without row", 1'b0, 4'd0);
    drive(4'hF, 3'h7);
    settle();
  endtask

  task automatic testGlitch();
    int bad = 0;
    drive(4'b1101, 3'b101);   // key 5
    repeat (N - 2) @(negedge clk);
    rowN = 4'hF;
    colN = 3'h7;
    repeat (3 * N) begin
      @(negedge clk);
      if (keyValid !== 1'b0) bad++;
    end
    testsRun++;
    if (bad != 0) begin
      testsFailed++;
      $display("FAIL R7 short pulse: valid high on %0d cycles, expected 0", bad);
    end
    check("R7 after pulse", 1'b0, 4'd0);
  endtask

  task automatic testLatency();
    drive(4'b1011, 3'b011);   // key 9
    repeat (N + 2) @(posedge clk);
    @(negedge clk);
    check("R8 not before edge N+3", 1'b0, 4'd0);
    @(negedge clk);
    check("R8 at edge N+3", 1'b1, 4'd9);
    drive(4'hF, 3'h7);
    repeat (N + 2) @(posedge clk);
    @(negedge clk);
    check("R8 release not early", 1'b1, 4'd9);
    @(negedge clk);
    check("R8 release at edge N+3", 1'b0, 4'd0);
  endtask

  task automatic testResetMidPress();
    drive(4'b0111, 3'b101);   // key 0
    settle();
    check("R1 key zero", 1'b1, 4'd0);
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    check("R6 reset while held", 1'b0, 4'd0);
    rst = 1'b0;
    repeat (N + 2) @(posedge clk);
    @(negedge clk);
    check("R6 refilter after reset", 1'b0, 4'd0);
    @(negedge clk);
    check("R6 key back after delay", 1'b1, 4'd0);
    drive(4'hF, 3'h7);
    settle();
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    testReset();
    testAllKeys();
    testMulti();
    testGlitch();
    testLatency();
    testResetMidPress();
    $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    testsRun++;
    testsFailed++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end
endmodule